// File: doc/BRIEF.md
# Converter-to-Host Parallel Capture Bridge

This block is the glue between a free-running sigma-delta converter with a 12-bit parallel output and a host processor's memory-mapped bus. The converter puts each finished word on its bus without being asked and flags it with a short data-ready pulse. The bridge brings that pulse into the host clock domain through a synchroniser, latches the word into a holding register on the pulse's rising edge, and raises a level interrupt. The host then reads the word at a decoded data address whenever it chooses. Between samples the host is free.

The converter's chip-select stays active at all times and is never toggled per sample. Its read input is likewise held active, except during a host write to the decoded control address. For that write the bridge releases read, asserts write, and drives the shared converter bus with the host's control word. Five test positions of that word are forced to zero. Capture is suppressed while the bridge owns the bus. If a second word arrives before the first has been read, an overrun flag is raised and the newer word is kept.

Top module: `adc_host_bridge`

## Requirements
- R1: After reset, `host_irq`, `host_ovr`, `host_rdata_oe` and `cnv_bus_oe` are 0, `cnv_cs_n` and `cnv_rd_n` are 0 and `cnv_wr_n` is 1.
- R2: A rising edge on `cnv_rdy` passes through a two-stage synchroniser and an edge detector. On the third rising `clk` edge after `cnv_rdy` first samples high, the word on `cnv_bus_i` is latched into the holding register and `host_irq` becomes 1.
- R3: However many cycles `cnv_rdy` stays high, one rising edge produces exactly one capture.
- R4: While `host_rd` is 1 and `host_addr` equals the data address (default 0), `host_rdata` shows the held word and `host_rdata_oe` is 1. `host_irq` is 0 from the next clock edge onward, unless a capture happens in that same cycle.
- R5: A read at any other address leaves `host_rdata_oe` at 0, drives `host_rdata` to zero, and leaves `host_irq` unchanged.
- R6: A capture while `host_irq` is still 1 and no data read is in progress sets `host_ovr` to 1. The holding register takes the newer word. The next data read clears `host_ovr`.
- R7: `cnv_cs_n` is 0 at all times. `cnv_rd_n` is 0 except during a control write.
- R8: While `host_wr` is 1 and `host_addr` equals the control address (default 1), the bridge does the following: `cnv_rd_n` is 1, `cnv_wr_n` is 0, `cnv_bus_oe` is 1, and `cnv_bus_o` equals `host_wdata` with bits 4, 5, 6, 9 and 10 forced to 0. Otherwise `cnv_bus_oe` is 0 and `cnv_wr_n` is 1.
- R9: A capture that falls in a cycle with a control write is dropped. The holding register, `host_irq` and `host_ovr` keep their values.
- R10: A write at any address other than the control address changes none of the converter strobes and leaves `cnv_bus_oe` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv_rdy | input | 1 | Converter data-ready, asynchronous to `clk` |
| cnv_bus_i | input | 12 | Converter parallel output word |
| cnv_bus_o | output | 12 | Sanitised control word toward the converter |
| cnv_bus_oe | output | 1 | Bridge drives the converter bus when 1 |
| cnv_cs_n | output | 1 | Converter chip-select, held low |
| cnv_rd_n | output | 1 | Converter read, high only during a control write |
| cnv_wr_n | output | 1 | Converter write, low only during a control write |
| host_addr | input | 4 | Host address |
| host_rd | input | 1 | Host read strobe, active high |
| host_wr | input | 1 | Host write strobe, active high |
| host_wdata | input | 12 | Host write data |
| host_rdata | output | 12 | Held word during a data read, else zero |
| host_rdata_oe | output | 1 | Bridge drives host data when 1 |
| host_irq | output | 1 | Fresh word waiting |
| host_ovr | output | 1 | A word was overwritten before being read |

## Verification
The hardest situation to reach from the ports is a capture that falls exactly in a control-write cycle. The capture cycle sits three edges after an asynchronous input and is not visible at the ports. The stimulus therefore holds the control write across the whole data-ready window, so the write covers the one internal capture cycle whatever its exact position. The bench then confirms through a data read that the older word survived. Overrun is reached by issuing two conversions with no read between them. It is checked by reading back the flag and the newer word.

// File: rtl/adc_bridge_pkg.sv
package adc_bridge_pkg;
  localparam int unsigned WORD_W = 12;
  localparam int unsigned ADDR_W = 4;
  localparam logic [WORD_W-1:0] TEST_BITS = 12'h670;

  function automatic logic [WORD_W-1:0] sanitize_ctrl(
      input logic [WORD_W-1:0] raw, input logic [WORD_W-1:0] forced);
    return raw & ~forced;
  endfunction

  function automatic logic addr_match(
      input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] target);
    return a == target;
  endfunction
endpackage

// File: rtl/rdy_sync.sv
module rdy_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_pulse
);
  localparam int unsigned LAST = STAGES - 1;
  logic [STAGES-1:0] chain;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= async_in;
  end

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain[LAST];
  end

  assign rise_pulse = chain[LAST] & ~prev_q;

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse |=> !rise_pulse);
endmodule

// File: rtl/capture_reg.sv
module capture_reg #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_req,
  input  logic         cap_block,
  input  logic         rd_hit,
  input  logic [W-1:0] word_in,
  output logic [W-1:0] held,
  output logic         irq,
  output logic         ovr
);
  logic cap_go;
  assign cap_go = cap_req & ~cap_block;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
      irq  <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      if (cap_go) held <= word_in;
      if (cap_go)      irq <= 1'b1;
      else if (rd_hit) irq <= 1'b0;
      if (cap_go && irq && !rd_hit) ovr <= 1'b1;
      else if (rd_hit)              ovr <= 1'b0;
    end
  end

  // R2
  cap_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_go |=> irq && held == $past(word_in));
  // R4
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !cap_go) |=> !irq);
  // R6
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_go && irq && !rd_hit) |=> ovr);
  // R9
  blocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_req && cap_block && !rd_hit) |=> $stable(held) && $stable(irq) && $stable(ovr));
endmodule

// File: rtl/strobe_steer.sv
module strobe_steer
  import adc_bridge_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DATA_ADDR = 4'd0,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'd1,
  parameter logic [WORD_W-1:0] FORCE0    = TEST_BITS
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  output logic              rd_hit,
  output logic              wr_hit,
  output logic              cs_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              bus_oe,
  output logic [WORD_W-1:0] bus_o
);
  always_comb begin
    rd_hit = rd & addr_match(addr, DATA_ADDR);
    wr_hit = wr & addr_match(addr, CTRL_ADDR);
    cs_n   = 1'b0;
    rd_n   = wr_hit;
    wr_n   = ~wr_hit;
    bus_oe = wr_hit;
    bus_o  = wr_hit ? sanitize_ctrl(wdata, FORCE0) : '0;
  end
endmodule

// File: rtl/adc_host_bridge.sv
module adc_host_bridge
  import adc_bridge_pkg::*;
#(
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] DATA_ADDR   = 4'd0,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 4'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnv_rdy,
  input  logic [WORD_W-1:0] cnv_bus_i,
  output logic [WORD_W-1:0] cnv_bus_o,
  output logic              cnv_bus_oe,
  output logic              cnv_cs_n,
  output logic              cnv_rd_n,
  output logic              cnv_wr_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  output logic              host_rdata_oe,
  output logic              host_irq,
  output logic              host_ovr
);
  logic              rdy_rise;
  logic              rd_hit;
  logic              wr_hit;
  logic [WORD_W-1:0] held_word;

  rdy_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_in(cnv_rdy), .rise_pulse(rdy_rise));

  strobe_steer #(.DATA_ADDR(DATA_ADDR), .CTRL_ADDR(CTRL_ADDR), .FORCE0(TEST_BITS)) steer_i (
    .addr(host_addr), .rd(host_rd), .wr(host_wr), .wdata(host_wdata),
    .rd_hit(rd_hit), .wr_hit(wr_hit), .cs_n(cnv_cs_n), .rd_n(cnv_rd_n),
    .wr_n(cnv_wr_n), .bus_oe(cnv_bus_oe), .bus_o(cnv_bus_o));

  capture_reg #(.W(WORD_W)) cap_i (
    .clk(clk), .rst_n(rst_n), .cap_req(rdy_rise), .cap_block(wr_hit),
    .rd_hit(rd_hit), .word_in(cnv_bus_i), .held(held_word),
    .irq(host_irq), .ovr(host_ovr));

  assign host_rdata_oe = rd_hit;
  assign host_rdata    = rd_hit ? held_word : '0;

  // R8
  test_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_bus_oe |-> ((cnv_bus_o & TEST_BITS) == '0) && cnv_rd_n && !cnv_wr_n);
  // R4
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_irq) |-> $past(host_rdata_oe));
  // R7
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_rd_n |-> cnv_bus_oe && host_wr);
endmodule

// File: tb/adc_host_bridge_tb_top.sv
module adc_host_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnv_rdy = 1'b0;
  logic [11:0] cnv_bus_i = '0;
  logic [11:0] cnv_bus_o;
  logic        cnv_bus_oe, cnv_cs_n, cnv_rd_n, cnv_wr_n;
  logic [3:0]  host_addr = '0;
  logic        host_rd = 1'b0, host_wr = 1'b0;
  logic [11:0] host_wdata = '0;
  logic [11:0] host_rdata;
  logic        host_rdata_oe, host_irq, host_ovr;

  int checks = 0;
  int errors = 0;
  logic [11:0] expq[$];
  logic        exp_ovr = 1'b0;

  always #5 clk = ~clk;

  adc_host_bridge dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: one conversion; pushes expected word when capture should happen
  task automatic convert(input logic [11:0] w, input int hi_cycles, input bit blocked);
    @(negedge clk);
    cnv_bus_i = w;
    cnv_rdy   = 1'b1;
    repeat (hi_cycles) @(negedge clk);
    cnv_rdy = 1'b0;
    repeat (3) @(negedge clk);
    if (!blocked) begin
      if (expq.size() != 0) begin
        expq.delete();
        exp_ovr = 1'b1;
      end
      expq.push_back(w);
    end
  endtask

  // monitor side: data read compared against scoreboard
  task automatic host_read(input string req);
    logic [11:0] e;
    @(negedge clk);
    host_addr = 4'd0;
    host_rd   = 1'b1;
    #1;
    chk({req, " rdata_oe"}, host_rdata_oe, 1);
    if (expq.size() != 0) begin
      e = expq.pop_front();
      chk({req, " rdata"}, host_rdata, e);
    end
    chk({req, " ovr"}, host_ovr, exp_ovr);
    @(negedge clk);
    host_rd = 1'b0;
    exp_ovr = 1'b0;
    chk({req, " irq cleared"}, host_irq, 0);
    chk({req, " ovr cleared"}, host_ovr, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] last_word;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq", host_irq, 0);
    chk("R1 ovr", host_ovr, 0);
    chk("R1 rdata_oe", host_rdata_oe, 0);
    chk("R1 bus_oe", cnv_bus_oe, 0);
    chk("R1 strobes", {cnv_cs_n, cnv_rd_n, cnv_wr_n}, 3'b001);
    rst_n = 1'b1;

    // R2 exact capture timing: irq rises on third edge
    @(negedge clk);
    cnv_bus_i = 12'hA5A;
    cnv_rdy = 1'b1;
    @(negedge clk); chk("R2 irq after 1 edge", host_irq, 0);
    @(negedge clk); chk("R2 irq after 2 edges", host_irq, 0);
    @(negedge clk); chk("R2 irq after 3 edges", host_irq, 1);
    cnv_rdy = 1'b0;
    repeat (3) @(negedge clk);
    expq.push_back(12'hA5A);
    host_read("R2 R4 word A5A");

    // R2 patterns
    convert(12'h000, 2, 0); chk("R2 irq zero word", host_irq, 1); host_read("R2 word 000");
    convert(12'hFFF, 2, 0); chk("R2 irq ones word", host_irq, 1); host_read("R2 word FFF");

    // R3 long data-ready gives one capture
    convert(12'h3C3, 10, 0);
    host_read("R3 word 3C3");
    repeat (4) @(negedge clk);
    chk("R3 no second irq", host_irq, 0);
    chk("R3 no overrun", host_ovr, 0);

    // R5 read at other address
    convert(12'h123, 2, 0);
    @(negedge clk);
    host_addr = 4'd5; host_rd = 1'b1;
    #1;
    chk("R5 rdata_oe", host_rdata_oe, 0);
    chk("R5 rdata zero", host_rdata, 0);
    @(negedge clk);
    host_rd = 1'b0;
    chk("R5 irq kept", host_irq, 1);
    host_read("R5 word 123");

    // R6 overrun
    convert(12'h111, 2, 0);
    chk("R6 no ovr yet", host_ovr, 0);
    convert(12'h222, 2, 0);
    chk("R6 ovr set", host_ovr, 1);
    host_read("R6 newest word");

    // R7 R8 control write masking
    @(negedge clk);
    host_addr = 4'd1; host_wdata = 12'hFFF; host_wr = 1'b1;
    #1;
    chk("R8 bus_oe", cnv_bus_oe, 1);
    chk("R8 masked FFF", cnv_bus_o, 12'h98F);
    chk("R7 R8 rd_n high", cnv_rd_n, 1);
    chk("R8 wr_n low", cnv_wr_n, 0);
    chk("R7 cs_n low", cnv_cs_n, 0);
    @(negedge clk);
    host_wdata = 12'h670;
    #1;
    chk("R8 test bits only", cnv_bus_o, 12'h000);
    @(negedge clk);
    host_wr = 1'b0;
    #1;
    chk("R8 released oe", cnv_bus_oe, 0);
    chk("R7 rd_n back low", cnv_rd_n, 0);

    // R10 write to other address
    host_addr = 4'd7; host_wdata = 12'hABC; host_wr = 1'b1;
    #1;
    chk("R10 strobes", {cnv_cs_n, cnv_rd_n, cnv_wr_n}, 3'b001);
    chk("R10 bus_oe", cnv_bus_oe, 0);
    @(negedge clk);
    host_wr = 1'b0;

    // R9 capture suppressed during control write
    convert(12'h456, 2, 0);
    last_word = 12'h456;
    host_read("R9 setup");
    convert(12'h456, 2, 0);   // irq set, word 456 pending
    @(negedge clk);
    host_addr = 4'd1; host_wdata = 12'h001; host_wr = 1'b1;
    cnv_bus_i = 12'h789; cnv_rdy = 1'b1;
    repeat (5) @(negedge clk);
    cnv_rdy = 1'b0;
    host_wr = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 no ovr", host_ovr, 0);
    chk("R9 irq kept", host_irq, 1);
    host_read("R9 old word kept");
    chk("R9 last word", last_word, 12'h456);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule